// File: doc/BRIEF.md
# Bit Test-and-Complement Execution Unit

This unit carries out a single test-and-complement step. It reads one bit of an operand, reports that bit on a carry output, and writes the operand back with only that bit inverted. The operand is either a register value supplied with the request or one byte of a bit string in byte-addressed memory. The caller picks a 16-bit or 32-bit operand size, and it picks whether the offset comes from a register or from a small immediate.

In register mode the unit reduces the offset to a bit index within the operand width. It returns the inverted word one cycle after the request is accepted. In memory mode the offset is a signed bit position that can reach anywhere in the string. The unit turns it into a byte address and a bit-within-byte. It then runs a read-modify-write of that one byte over a simple request/acknowledge memory port.

Only one operation is in flight at a time. The caller watches `busy` and waits for the one-cycle `done` pulse. The carry output and the result stay valid until the next request is taken. The remaining arithmetic flags have no defined value after this operation, so the unit drives them to zero and marks them as not valid.

Top module: `btc_unit`

## Requirements
- R1: `cf` equals the selected bit as it was before inversion, in both register and memory mode.
- R2: In register mode, `result` equals `req_base` with exactly the selected bit inverted and all other bits, including bits 31..16 for a 16-bit operand, unchanged.
- R3: In register mode with a register offset, the bit index is `req_offset` modulo 16 when `req_wide`=0 and modulo 32 when `req_wide`=1; higher offset bits have no effect.
- R4: In memory mode with a register offset, `req_offset` is a signed two's-complement bit position. The byte accessed is `req_base` + floor(offset / 8) (wrapping at 32 bits), and the bit within it is offset bits 2..0.
- R5: When `req_imm`=1, only bits 4..0 of `req_offset` are used, as an unsigned value 0..31. Register mode then still reduces it modulo the operand width.
- R6: A memory operation first holds a read (`mem_req`=1, `mem_we`=0) until `mem_ack`, with `mem_rdata` valid in the ack cycle. It then holds a write (`mem_we`=1) to the same address, carrying the read byte with only the selected bit inverted, until `mem_ack`. After that, `done` is high for exactly one cycle.
- R7: In memory mode, `result` at `done` holds the written byte in bits 7..0 and zero above.
- R8: A request (`req_valid`=1) is taken only on a clock edge where `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. Requests presented while busy, including in the `done` cycle, are ignored. After reset `busy`, `done`, `mem_req`, `result` and `cf` are zero.
- R9: A register-mode operation asserts `done` in the first cycle after acceptance and makes no memory access.
- R10: `result` and `cf` do not change from `done` until the next request is accepted.
- R11: `aux_flags` (overflow, sign, zero, aux-carry, parity) is always zero and `aux_flags_valid` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_mem | input | 1 | 1 = memory bit string, 0 = register operand |
| req_wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand |
| req_imm | input | 1 | 1 = offset is an immediate (bits 4..0 only) |
| req_base | input | 32 | Register value or byte address of bit 0 of the string |
| req_offset | input | 32 | Bit offset |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Updated register value, or written byte zero-extended |
| cf | output | 1 | Selected bit before inversion |
| aux_flags | output | 5 | Undefined arithmetic flags, driven zero |
| aux_flags_valid | output | 1 | Always low: aux_flags carry no meaning |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack during a read |
| mem_ack | input | 1 | Access completed |

## Verification
Two events can land on the same clock edge. The first is a new request arriving in the cycle where the previous operation signals `done`. The second is a memory acknowledge arriving in the first cycle of a read or write request. The bench sometimes keeps `req_valid` high with scrambled operands for the whole operation and through the `done` cycle. Its memory model answers each access after a random latency of zero to three cycles. It judges the outcome by the address and byte it sees written, by the carry and result at `done`, and by `busy` being low in the cycle after `done` with the result unchanged.

// File: rtl/btc_pkg.sv
package btc_pkg;
  parameter int unsigned DW     = 32;          // register operand width
  parameter int unsigned AW     = 32;          // address and memory offset width
  parameter int unsigned BW     = 8;           // memory byte width
  parameter int unsigned IMM_W  = 5;           // immediate offset width
  parameter int unsigned NFLAG  = 5;           // count of undefined flags
  localparam int unsigned IW    = $clog2(DW);  // bit index width in a word
  localparam int unsigned BIW   = $clog2(BW);  // bit index width in a byte

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } btc_state_e;

  typedef struct packed {
    logic [AW-1:0]  addr;
    logic [BIW-1:0] bit_sel;
  } mem_loc_t;

  // Word bit index: full width for a wide operand, half width otherwise.
  function automatic logic [IW-1:0] reg_bit_index(input logic [IW-1:0] off,
                                                  input logic wide);
    return wide ? off : {1'b0, off[IW-2:0]};
  endfunction

  // Offset used in memory mode: immediate is unsigned and narrow.
  function automatic logic [AW-1:0] eff_offset(input logic [AW-1:0] off,
                                               input logic imm);
    return imm ? AW'(off[IMM_W-1:0]) : off;
  endfunction

  // Signed bit position to byte address plus bit within the byte.
  function automatic mem_loc_t mem_locate(input logic [AW-1:0] base,
                                          input logic [AW-1:0] eff);
    mem_loc_t          loc;
    logic signed [AW-1:0] pos;
    logic [AW-1:0]     step;
    pos         = $signed(eff);
    step        = pos >>> BIW;
    loc.addr    = base + step;
    loc.bit_sel = eff[BIW-1:0];
    return loc;
  endfunction

  function automatic logic [BW-1:0] flip_byte(input logic [BW-1:0] v,
                                              input logic [BIW-1:0] k);
    return v ^ (BW'(1) << k);
  endfunction
endpackage

// File: rtl/btc_reg_path.sv
module btc_reg_path
  import btc_pkg::*;
(
  input  logic [DW-1:0] operand,
  input  logic [IW-1:0] off_low,
  input  logic          wide,
  output logic [DW-1:0] flipped,
  output logic          sel_bit
);
  logic [IW-1:0] idx;

  assign idx = reg_bit_index(off_low, wide);

  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign flipped[g] = operand[g] ^ (idx == IW'(g));
  end

  assign sel_bit = operand[idx];
endmodule

// File: rtl/btc_addr_gen.sv
module btc_addr_gen
  import btc_pkg::*;
(
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  input  logic          imm,
  output mem_loc_t      loc
);
  logic [AW-1:0] eff;

  assign eff = eff_offset(offset, imm);
  assign loc = mem_locate(base, eff);
endmodule

// File: rtl/btc_mem_seq.sv
module btc_mem_seq
  import btc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_reg,
  input  logic          start_mem,
  input  mem_loc_t      loc_in,
  input  logic [DW-1:0] reg_result_in,
  input  logic          reg_cf_in,
  input  logic          mem_ack,
  input  logic [BW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          cf
);
  btc_state_e     state_q;
  logic [AW-1:0]  addr_q;
  logic [BIW-1:0] bitsel_q;
  logic [BW-1:0]  rd_byte_q;
  logic [BW-1:0]  wr_byte_q;
  logic [DW-1:0]  result_q;
  logic           cf_q;
  logic [BW-1:0]  mod_byte;

  // Named internal events
  logic rd_done, wr_done;
  assign rd_done  = (state_q == ST_RD) && mem_ack;
  assign wr_done  = (state_q == ST_WR) && mem_ack;
  assign mod_byte = flip_byte(mem_rdata, bitsel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      bitsel_q  <= '0;
      rd_byte_q <= '0;
      wr_byte_q <= '0;
      result_q  <= '0;
      cf_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_reg) begin
            result_q <= reg_result_in;
            cf_q     <= reg_cf_in;
            state_q  <= ST_FIN;
          end else if (start_mem) begin
            addr_q   <= loc_in.addr;
            bitsel_q <= loc_in.bit_sel;
            state_q  <= ST_RD;
          end
        end
        ST_RD: begin
          if (rd_done) begin
            rd_byte_q <= mem_rdata;
            wr_byte_q <= mod_byte;
            cf_q      <= mem_rdata[bitsel_q];
            result_q  <= DW'(mod_byte);
            state_q   <= ST_WR;
          end
        end
        ST_WR: begin
          if (wr_done) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = wr_byte_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign result    = result_q;
  assign cf        = cf_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_HOLD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R6
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && $stable(mem_addr))); // R6
  AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($countones(mem_wdata ^ rd_byte_q) == 1)); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_reg && !start_mem) |=> ($stable(result) && $stable(cf))); // R10
endmodule

// File: rtl/btc_unit.sv
module btc_unit
  import btc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_mem,
  input  logic                req_wide,
  input  logic                req_imm,
  input  logic [DW-1:0]       req_base,
  input  logic [AW-1:0]       req_offset,
  output logic                busy,
  output logic                done,
  output logic [DW-1:0]       result,
  output logic                cf,
  output logic [NFLAG-1:0]    aux_flags,
  output logic                aux_flags_valid,
  output logic                mem_req,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [BW-1:0]       mem_wdata,
  input  logic [BW-1:0]       mem_rdata,
  input  logic                mem_ack
);
  logic          accept, start_reg, start_mem;
  logic [DW-1:0] reg_flipped;
  logic          reg_sel;
  mem_loc_t      loc;

  assign accept    = req_valid && !busy;
  assign start_reg = accept && !req_mem;
  assign start_mem = accept && req_mem;

  btc_reg_path u_reg (
    .operand (req_base),
    .off_low (req_offset[IW-1:0]),
    .wide    (req_wide),
    .flipped (reg_flipped),
    .sel_bit (reg_sel)
  );

  btc_addr_gen u_addr (
    .base   (req_base[AW-1:0]),
    .offset (req_offset),
    .imm    (req_imm),
    .loc    (loc)
  );

  btc_mem_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_reg     (start_reg),
    .start_mem     (start_mem),
    .loc_in        (loc),
    .reg_result_in (reg_flipped),
    .reg_cf_in     (reg_sel),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .busy          (busy),
    .done          (done),
    .result        (result),
    .cf            (cf)
  );

  assign aux_flags       = '0;
  assign aux_flags_valid = 1'b0;

  AST_REG_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_reg |=> ($countones(result ^ $past(req_base)) == 1)); // R2
  AST_REG_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    start_reg |=> (done && !mem_req)); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> $stable(mem_addr)); // R8
endmodule

// File: tb/tb_btc_unit.sv
`timescale 1ns/1ps
module tb_btc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_mem = 1'b0, req_wide = 1'b0, req_imm = 1'b0;
  logic [31:0] req_base = '0, req_offset = '0;
  logic        busy, done, cf, aux_flags_valid, mem_req, mem_we;
  logic [31:0] result, mem_addr;
  logic [4:0]  aux_flags;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  btc_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mem(req_mem),
    .req_wide(req_wide), .req_imm(req_imm), .req_base(req_base),
    .req_offset(req_offset), .busy(busy), .done(done), .result(result),
    .cf(cf), .aux_flags(aux_flags), .aux_flags_valid(aux_flags_valid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // Sparse memory model with random ack latency
  logic [7:0]  store [logic [31:0]];
  int          rd_cnt = 0, wr_cnt = 0, lat = 0;
  logic [31:0] rd_addr_seen = '0, wr_addr_seen = '0;
  logic [7:0]  wr_data_seen = '0;

  function automatic logic [7:0] mem_peek(input logic [31:0] a);
    if (store.exists(a)) return store[a];
    return a[7:0] ^ a[23:16] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          store[mem_addr] = mem_wdata;
          wr_cnt = wr_cnt + 1;
          wr_addr_seen = mem_addr;
          wr_data_seen = mem_wdata;
        end else begin
          mem_rdata <= mem_peek(mem_addr);
          rd_cnt = rd_cnt + 1;
          rd_addr_seen = mem_addr;
        end
        lat = int'($urandom_range(0, 3));
      end else begin
        lat = lat - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench view of the index rules
  function automatic int reg_idx(input logic [31:0] o, input bit w, input bit im);
    int unsigned v;
    v = im ? (o & 32'd31) : o;
    return w ? int'(v % 32) : int'(v % 16);
  endfunction

  function automatic void mem_target(input logic [31:0] b, input logic [31:0] o,
                                     input bit im, output logic [31:0] ea,
                                     output logic [2:0] eb);
    int s, q;
    s  = im ? int'(o & 32'd31) : int'(o);
    q  = (s - (s & 7)) / 8;
    ea = b + 32'(q);
    eb = 3'(s & 7);
  endfunction

  task automatic run_op(input bit m, input bit w, input bit im,
                        input logic [31:0] b, input logic [31:0] o, input bit noise);
    logic [31:0] ea, exp_res, held;
    logic [2:0]  eb;
    logic [7:0]  orig;
    logic        exp_cf, held_cf;
    int          k, cyc;
    ea = '0; eb = '0;
    while (busy) @(negedge clk);
    if (m) begin
      mem_target(b, o, im, ea, eb);
      orig    = mem_peek(ea);
      exp_cf  = orig[eb];
      exp_res = {24'h0, orig ^ (8'h1 << eb)};
    end else begin
      k       = reg_idx(o, w, im);
      exp_cf  = b[k];
      exp_res = b ^ (32'h1 << k);
    end
    rd_cnt = 0; wr_cnt = 0;
    req_valid = 1'b1; req_mem = m; req_wide = w; req_imm = im;
    req_base = b; req_offset = o;
    @(negedge clk);
    chk(busy == 1'b1, "R8 busy after accept", {31'h0, busy}, 32'h1);
    cyc = 0;
    while (!done && cyc < 200) begin
      if (noise) begin
        req_valid = 1'b1; req_mem = 1'($urandom);
        req_base = $urandom; req_offset = $urandom;
      end else req_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    if (noise) begin
      req_valid = 1'b1; req_base = $urandom; req_offset = $urandom;
    end else req_valid = 1'b0;
    chk(done == 1'b1, "R6 done reached", {31'h0, done}, 32'h1);
    chk(cf == exp_cf, m ? "R1 cf memory" : "R1 cf register", {31'h0, cf}, {31'h0, exp_cf});
    chk(aux_flags == 5'h0 && !aux_flags_valid, "R11 undefined flags",
        {26'h0, aux_flags_valid, aux_flags}, 32'h0);
    if (m) begin
      chk(result == exp_res, im ? "R5 R7 memory imm result" : "R7 memory result", result, exp_res);
      chk(rd_cnt == 1 && wr_cnt == 1, "R6 one read one write", 32'(rd_cnt * 16 + wr_cnt), 32'h11);
      chk(rd_addr_seen == ea, im ? "R5 read address" : "R4 read address", rd_addr_seen, ea);
      chk(wr_addr_seen == ea, "R6 write address", wr_addr_seen, ea);
      chk(wr_data_seen == exp_res[7:0], "R6 write byte", {24'h0, wr_data_seen}, exp_res);
    end else begin
      chk(result == exp_res, im ? "R5 register imm" : (w ? "R2 register 32" : "R3 register 16"),
          result, exp_res);
      chk(cyc == 0, "R9 register done next cycle", 32'(cyc), 32'h0);
      chk(rd_cnt == 0 && wr_cnt == 0, "R9 no memory access", 32'(rd_cnt + wr_cnt), 32'h0);
    end
    held = result; held_cf = cf;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b0, noise ? "R8 request in done cycle ignored" : "R8 idle after done",
        {31'h0, busy}, 32'h0);
    chk(result == held && cf == held_cf, "R10 result held", result, held);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0BC7_1357));
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0, "R8 reset outputs",
        {29'h0, busy, done, mem_req}, 32'h0);
    chk(result == 0 && cf == 0, "R8 reset result", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(aux_flags == 0 && !aux_flags_valid, "R11 flags after reset", {27'h0, aux_flags}, 32'h0);

    // Directed corners
    run_op(0, 0, 0, 32'hDEAD_BEEF, 32'd17,        0); // R3 index 1
    run_op(0, 1, 0, 32'h1234_5678, 32'd63,        0); // R3 index 31
    run_op(0, 0, 0, 32'hFFFF_0000, 32'hFFFF_FFFF, 0); // R3 index 15
    run_op(0, 1, 1, 32'h0000_0000, 32'hFFFF_FFE5, 0); // R5 index 5
    run_op(0, 0, 1, 32'hAAAA_5555, 32'd31,        0); // R5 imm 31 mod 16
    run_op(1, 1, 0, 32'h0000_1000, 32'hFFFF_FFFF, 0); // R4 byte base-1 bit 7
    run_op(1, 1, 0, 32'h8000_0000, 32'h8000_0000, 0); // R4 most negative
    run_op(1, 1, 0, 32'h0000_0010, 32'h7FFF_FFFF, 0); // R4 most positive
    run_op(1, 0, 1, 32'h0000_2000, 32'hFFFF_FFFF, 0); // R5 imm 31
    run_op(1, 1, 0, 32'h0000_3000, 32'd9,         0); // R1 toggle
    run_op(1, 1, 0, 32'h0000_3000, 32'd9,         0); // R1 toggle back
    run_op(1, 1, 0, 32'h0000_4000, 32'd3,         1); // R8 noise in memory op
    run_op(0, 1, 0, 32'h0F0F_0F0F, 32'd4,         1); // R8 noise in register op

    // Constrained random mix
    for (int i = 0; i < 120; i++) begin
      bit m, w, im, nz;
      logic [31:0] b, o;
      m  = 1'($urandom);
      w  = 1'($urandom);
      im = ($urandom % 4) == 0;
      nz = ($urandom % 4) == 0;
      b  = m ? ((($urandom % 2) == 0) ? (32'h0000_5000 + ($urandom % 64)) : $urandom) : $urandom;
      o  = (($urandom % 2) == 0) ? 32'($signed($urandom_range(0, 200)) - 100) : $urandom;
      run_op(m, w, im, b, o, nz);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule